// File: doc/BRIEF.md
# Pushbutton Input Port with Sticky Falling-Edge Flags

This block is a narrow input port for a few slow external signals, usually pushbuttons that idle high and pull low when pressed. Each pin passes through a two-stage synchronizer. Software can read the synchronized levels through a small word-addressed register bus.

A high-to-low transition on any synchronized pin sets a flag for that pin. The flag is sticky: it stays set after the pin returns high, and software clears it by writing a one to its bit position. A per-pin enable register selects which flags may drive a single shared interrupt request line. A service routine reads the flags, handles the press, and writes the same value back to acknowledge it.

The bus has four word slots, selected by a two-bit word index (the byte offset divided by four). Index 0 holds the pin levels. Index 1 is a placeholder direction slot that reads as zero. Index 2 holds the interrupt enables. Index 3 holds the edge flags. Reads are combinational from the selected slot. A write takes effect on the clock edge where the write strobe is high.

Top module: `btn_edge_port`

## Requirements
- R1: Reading word index 0 returns the synchronized pin levels in bits [3:0], with bits [31:4] zero. A change on the pins appears there after the second rising clock edge.
- R2: A high-to-low change on pin i sets bit i of the edge-flag register (word index 3). The flag is visible after the third rising edge following the pin change, and it stays set after the pin returns high.
- R3: A low-to-high change on a pin leaves the edge-flag register unchanged.
- R4: Writing to word index 3 clears every flag whose write-data bit is 1 and leaves every flag whose write-data bit is 0 unchanged.
- R5: When a new falling edge on pin i and a write of 1 to flag bit i land on the same clock edge, flag bit i ends up set.
- R6: The irq output is high exactly when some flag bit i and enable bit i (word index 2) are both 1. Flags whose enable is 0 do not raise it.
- R7: Once raised, irq stays high until every flag that is set together with its enable has been cleared. Clearing other flags does not drop it.
- R8: A write to word index 2 stores write-data bits [3:0] as the enables. A read returns them in bits [3:0], with bits [31:4] zero.
- R9: Word index 1 always reads zero. Writes to word index 1 or word index 0 change no enable, flag or level.
- R10: While rst_n is low, and once it is released, the enables and the flags are zero and irq is low. The level register starts from the idle-high value, so a pin held high across reset produces no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| pins_in | input | 4 | Asynchronous input pins, idle high |
| bus_word | input | 2 | Register word index (byte offset divided by four) |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 4 | Write data, the bits that map onto the pins |
| bus_rdata | output | 32 | Read data of the selected word, upper bits zero |
| irq | output | 1 | Interrupt request, high while an enabled flag is set |

## Verification
The edge detector is driven with several pin patterns. A single pin falling and later rising shows that the flag is sticky and that a rise sets nothing. Two pins falling at different times, one enabled and one not, separate flag capture from interrupt gating. All pins falling together show that the bits are independent. Acknowledge writes use mixed one/zero patterns, which expose a clear applied to the wrong bits. One falling edge is timed to meet a clear write on the same edge, which separates edge-over-clear priority from clear-over-edge priority. Writes to the level and direction slots, followed by reads of every slot, show that those slots hold no state.

// File: rtl/btn_port_pkg.sv
package btn_port_pkg;

  // Word slots of the register bus; the index is the byte offset divided by four.
  typedef enum logic [1:0] {
    SLOT_LEVEL = 2'd0,
    SLOT_DIR   = 2'd1,
    SLOT_ENAB  = 2'd2,
    SLOT_FLAG  = 2'd3
  } port_slot_e;

  localparam int unsigned SLOT_IDX_W = 2;

endpackage

// File: rtl/btn_rst_sync.sv
module btn_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/btn_pin_sync.sv
module btn_pin_sync #(
  parameter int unsigned       N_PINS     = 4,
  parameter int unsigned       STAGES     = 2,
  parameter logic [N_PINS-1:0] IDLE_LEVEL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pins_in,
  output logic [N_PINS-1:0] pins_sync
);

  logic [N_PINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [N_PINS-1:0] stage_d;

    if (s == 0) begin : g_first
      always_comb stage_d = pins_in;
    end else begin : g_rest
      always_comb stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= IDLE_LEVEL;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign pins_sync = stage_q[STAGES-1];

endmodule

// File: rtl/btn_fall_detect.sv
module btn_fall_detect #(
  parameter int unsigned       N_PINS     = 4,
  parameter logic [N_PINS-1:0] IDLE_LEVEL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] level,
  output logic [N_PINS-1:0] fall_pulse
);

  logic [N_PINS-1:0] prev_q;
  logic [N_PINS-1:0] prev_d;

  always_comb begin
    prev_d = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= IDLE_LEVEL;
    end else begin
      prev_q <= prev_d;
    end
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_bit
    assign fall_pulse[i] = prev_q[i] & ~level[i];
  end

endmodule

// File: rtl/btn_capture_regs.sv
module btn_capture_regs #(
  parameter int unsigned N_PINS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enab_we,
  input  logic              flag_we,
  input  logic [N_PINS-1:0] wdata,
  input  logic [N_PINS-1:0] fall_pulse,
  output logic [N_PINS-1:0] enab_q,
  output logic [N_PINS-1:0] flag_q,
  output logic              irq
);

  logic [N_PINS-1:0] enab_d;
  logic [N_PINS-1:0] flag_d;
  logic [N_PINS-1:0] ack_bits;

  always_comb begin
    ack_bits = flag_we ? wdata : '0;
    enab_d   = enab_q;
    if (enab_we) begin
      enab_d = wdata;
    end
  end

  // A fresh edge is ORed in after the acknowledge, so it survives a same-edge clear.
  for (genvar i = 0; i < N_PINS; i++) begin : g_flag
    always_comb begin
      flag_d[i] = (flag_q[i] & ~ack_bits[i]) | fall_pulse[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enab_q <= '0;
    end else if (enab_we) begin
      enab_q <= enab_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign irq = |(flag_q & enab_q);

endmodule

// File: rtl/btn_edge_port.sv
module btn_edge_port
  import btn_port_pkg::*;
#(
  parameter int unsigned       N_PINS      = 4,
  parameter int unsigned       DATA_W      = 32,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       RST_STAGES  = 2,
  parameter logic [N_PINS-1:0] IDLE_LEVEL  = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_PINS-1:0]     pins_in,
  input  logic [SLOT_IDX_W-1:0] bus_word,
  input  logic                  bus_wr,
  input  logic [N_PINS-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  irq
);

  localparam int unsigned PAD_W = DATA_W - N_PINS;

  logic              rst_sync_n;
  logic [N_PINS-1:0] level_sync;
  logic [N_PINS-1:0] fall_pulse;
  logic [N_PINS-1:0] enab_q;
  logic [N_PINS-1:0] flag_q;
  logic              enab_we;
  logic              flag_we;
  port_slot_e        slot;

  btn_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  btn_pin_sync #(
    .N_PINS     (N_PINS),
    .STAGES     (SYNC_STAGES),
    .IDLE_LEVEL (IDLE_LEVEL)
  ) u_pin_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pins_in   (pins_in),
    .pins_sync (level_sync)
  );

  btn_fall_detect #(
    .N_PINS     (N_PINS),
    .IDLE_LEVEL (IDLE_LEVEL)
  ) u_fall (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .level      (level_sync),
    .fall_pulse (fall_pulse)
  );

  always_comb begin
    slot    = port_slot_e'(bus_word);
    enab_we = bus_wr && (slot == SLOT_ENAB);
    flag_we = bus_wr && (slot == SLOT_FLAG);
  end

  btn_capture_regs #(
    .N_PINS (N_PINS)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .enab_we    (enab_we),
    .flag_we    (flag_we),
    .wdata      (bus_wdata),
    .fall_pulse (fall_pulse),
    .enab_q     (enab_q),
    .flag_q     (flag_q),
    .irq        (irq)
  );

  always_comb begin
    unique case (slot)
      SLOT_LEVEL: bus_rdata = {{PAD_W{1'b0}}, level_sync};
      SLOT_ENAB:  bus_rdata = {{PAD_W{1'b0}}, enab_q};
      SLOT_FLAG:  bus_rdata = {{PAD_W{1'b0}}, flag_q};
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/btn_edge_port_chk.sv
module btn_edge_port_chk
  import btn_port_pkg::*;
#(
  parameter int unsigned N_PINS = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic [SLOT_IDX_W-1:0] bus_word,
  input logic                  bus_wr,
  input logic [N_PINS-1:0]     bus_wdata,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic                  irq,
  input logic [N_PINS-1:0]     fall_pulse,
  input logic [N_PINS-1:0]     flag_q,
  input logic [N_PINS-1:0]     enab_q
);

  // R1 / R8: the padding above the pin field never carries data.
  p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rdata[DATA_W-1:N_PINS] == '0);

  // R9: the direction slot reads zero.
  p_dir_zero_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_word == SLOT_DIR) |-> (bus_rdata == '0));

  // R2 / R5: a detected fall shows up in the flags on the next edge, even under a clear.
  p_fall_sets_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|fall_pulse) |=> ((flag_q & $past(fall_pulse)) == $past(fall_pulse)));

  // R4: without an acknowledge write, no flag falls back to zero.
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_wr && bus_word == SLOT_FLAG) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R8: an enable write is stored.
  p_enab_store_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_word == SLOT_ENAB) |=> (enab_q == $past(bus_wdata)));

  // R7: irq holds unless software touches the flags or the enables.
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq && !(bus_wr && (bus_word == SLOT_FLAG || bus_word == SLOT_ENAB))) |=> irq);

endmodule

bind btn_edge_port btn_edge_port_chk #(
  .N_PINS (N_PINS),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_word   (bus_word),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq        (irq),
  .fall_pulse (fall_pulse),
  .flag_q     (flag_q),
  .enab_q     (enab_q)
);

// File: tb/btn_edge_port_test.sv
`timescale 1ns/1ps
module btn_edge_port_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pins_in = 4'hF;
  logic [1:0]  bus_word = 2'd0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_wdata = 4'h0;
  logic [31:0] bus_rdata;
  logic        irq;

  logic probe_rd = 1'b0;
  logic probe_irq = 1'b0;
  int   n_checks = 0;
  int   n_fails = 0;
  bit   done = 1'b0;

  localparam logic [1:0] W_LEVEL = 2'd0;
  localparam logic [1:0] W_DIR   = 2'd1;
  localparam logic [1:0] W_ENAB  = 2'd2;
  localparam logic [1:0] W_FLAG  = 2'd3;

  typedef struct {
    logic [31:0] exp;
    string       tag;
    bit          is_irq;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  btn_edge_port uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_in   (pins_in),
    .bus_word  (bus_word),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bus_wr = 1'b0; probe_rd = 1'b0; probe_irq = 1'b0;
    end
  endtask

  task automatic set_pins(input logic [3:0] v);
    @(negedge clk);
    pins_in = v; bus_wr = 1'b0; probe_rd = 1'b0; probe_irq = 1'b0;
  endtask

  task automatic wr(input logic [1:0] w, input logic [3:0] d);
    @(negedge clk);
    bus_word = w; bus_wdata = d; bus_wr = 1'b1; probe_rd = 1'b0; probe_irq = 1'b0;
  endtask

  task automatic rd(input logic [1:0] w, input logic [31:0] e, input string t);
    @(negedge clk);
    sb_q.push_back('{exp: e, tag: t, is_irq: 1'b0});
    bus_word = w; bus_wr = 1'b0; probe_rd = 1'b1; probe_irq = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    sb_q.push_back('{exp: {31'b0, e}, tag: t, is_irq: 1'b1});
    bus_wr = 1'b0; probe_rd = 1'b0; probe_irq = 1'b1;
  endtask

  // Monitor: pops one expected item per probed cycle, sampling mid-low-phase.
  always begin
    @(negedge clk);
    #1;
    if (probe_rd || probe_irq) begin
      if (sb_q.size() == 0) begin
        n_checks++; n_fails++;
        $display("FAIL scoreboard: probe with empty queue, actual=empty expected=item");
      end else begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.is_irq ? {31'b0, irq} : bus_rdata;
        n_checks++;
        if (act !== it.exp) begin
          n_fails++;
          $display("FAIL %s: actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    #(20000 * 5);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog (R1..): actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R10 reset state
    rd(W_LEVEL, 32'h0000000F, "R10 level after reset");
    rd(W_ENAB,  32'h0, "R10 enables after reset");
    rd(W_FLAG,  32'h0, "R10 flags after reset");
    chk_irq(1'b0, "R10 irq after reset");

    // R8 enable store, upper write bits not present
    wr(W_ENAB, 4'h5);
    rd(W_ENAB, 32'h00000005, "R8 enable readback");

    // R1, R2, R6: pin 0 falls
    set_pins(4'hE); idle(3);
    rd(W_LEVEL, 32'h0000000E, "R1 level after pin0 low");
    rd(W_FLAG,  32'h1, "R2 flag after pin0 fall");
    chk_irq(1'b1, "R6 irq with enabled flag");

    // R2 sticky, R7 hold
    set_pins(4'hF); idle(3);
    rd(W_LEVEL, 32'h0000000F, "R1 level after pin0 high");
    rd(W_FLAG,  32'h1, "R2 flag sticky after release");
    chk_irq(1'b1, "R7 irq held");

    // R4 zeros leave bits, R7 unrelated clear
    wr(W_FLAG, 4'hE);
    rd(W_FLAG, 32'h1, "R4 write-zero keeps flag");
    chk_irq(1'b1, "R7 irq after unrelated clear");

    // pin 1 (not enabled) falls and rises
    set_pins(4'hD); idle(3);
    set_pins(4'hF); idle(3);
    rd(W_FLAG, 32'h3, "R2 second flag");
    wr(W_FLAG, 4'h1);
    rd(W_FLAG, 32'h2, "R4 clear bit0 only");
    chk_irq(1'b0, "R6 masked flag gives no irq");
    wr(W_FLAG, 4'h2);

    // R3 rising edge
    set_pins(4'hB); idle(3);
    rd(W_FLAG, 32'h4, "R2 pin2 fall");
    wr(W_FLAG, 4'h4);
    rd(W_FLAG, 32'h0, "R4 clear pin2 flag");
    set_pins(4'hF); idle(3);
    rd(W_FLAG, 32'h0, "R3 rise sets nothing");
    chk_irq(1'b0, "R3 irq low after rise");

    // R5 edge meets clear on same edge
    set_pins(4'hE); idle(1);
    wr(W_FLAG, 4'h1);
    idle(2);
    rd(W_FLAG, 32'h1, "R5 edge wins over clear");
    chk_irq(1'b1, "R5 irq from surviving flag");
    set_pins(4'hF); idle(3);
    wr(W_FLAG, 4'h1);
    rd(W_FLAG, 32'h0, "R4 acknowledge clears");
    chk_irq(1'b0, "R7 irq drops after clear");

    // R9 direction and level slots hold nothing
    wr(W_DIR, 4'hF);
    rd(W_DIR, 32'h0, "R9 direction reads zero");
    wr(W_LEVEL, 4'h0);
    rd(W_LEVEL, 32'h0000000F, "R9 level unaffected by write");
    rd(W_ENAB,  32'h5, "R9 enables unaffected");
    rd(W_FLAG,  32'h0, "R9 flags unaffected");

    // all pins fall together
    set_pins(4'h0); idle(3);
    rd(W_LEVEL, 32'h0, "R1 all pins low");
    rd(W_FLAG,  32'hF, "R2 all flags set");
    wr(W_ENAB, 4'h8);
    chk_irq(1'b1, "R6 irq from pin3");
    wr(W_FLAG, 4'h7);
    chk_irq(1'b1, "R7 irq held after clearing others");
    rd(W_FLAG, 32'h8, "R4 only bit3 left");
    wr(W_FLAG, 4'h8);
    chk_irq(1'b0, "R7 irq low after responsible clear");
    rd(W_FLAG, 32'h0, "R4 flags empty");

    // R10 reset mid-run with state set
    set_pins(4'hF); idle(3);
    set_pins(4'h7); idle(3);
    set_pins(4'hF); idle(3);
    chk_irq(1'b1, "R6 irq before reset");
    @(negedge clk); rst_n = 1'b0; probe_rd = 1'b0; probe_irq = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(4);
    rd(W_ENAB,  32'h0, "R10 enables after second reset");
    rd(W_FLAG,  32'h0, "R10 flags after second reset");
    rd(W_LEVEL, 32'h0000000F, "R10 level after second reset");
    chk_irq(1'b0, "R10 irq after second reset");

    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule